// File: doc/BRIEF.md
# Three-Axis Sample Output Registers

This block sits between a tri-axis measurement pipeline and a register-mapped bus slave. Each time the pipeline presents a sample strobe, the block stores one 12-bit two's-complement value for each of the X, Y and Z axes. It then serves those values to the bus as pairs of byte registers, one low byte and one high byte per axis. A mode input chooses how the 12 bits sit in the 16-bit word. In right-justified mode the sign bit is copied into the top nibble. In left-justified mode the value is shifted up four places and zero-filled.

A status byte reports, per axis, whether unread data is waiting and whether a sample was lost because a newer one overwrote it. It also gives a combined "all axes fresh" flag and a combined "any axis overran" flag. Reading an axis high byte consumes that axis's data and clears its flags. Reading a low byte freezes the matching high byte in a shadow, so that a two-byte read stays coherent even if a new sample lands between the two accesses. A data-ready output, gated by an enable input, follows the all-fresh flag.

Top module: `axis_data_out`

## Requirements
- R1: After reset every stored sample is zero, every status flag is clear, and `drdy` is low.
- R2: Register addresses are fixed. Status is at 27h. X low/high are at 28h/29h, Y at 2Ah/2Bh and Z at 2Ch/2Dh. A read of any other address returns 00h.
- R3: With `align_left` = 0, a low byte read returns sample bits 7..0. A high byte read returns four copies of sample bit 11 followed by sample bits 11..8.
- R4: With `align_left` = 1, the 16-bit word is the sample shifted left by four with zero fill. The low byte is {sample[3:0], 0000} and the high byte is sample[11:4].
- R5: A cycle with `smp_vld` high stores all three samples and, from the next cycle on, sets each axis new-data flag. These flags are status bits 0 (X), 1 (Y) and 2 (Z). Status bit 3 is high exactly when all three are set.
- R6: A high byte read clears that axis's new-data and overrun flags at the next clock edge, and a low byte read clears neither. When a high byte read and a sample strobe fall in the same cycle, the clear is applied first. The new-data flag then ends set and the overrun flag ends clear.
- R7: A sample strobe that arrives while an axis new-data flag is still set (and not being cleared) sets that axis overrun flag. These flags are status bits 4 (X), 5 (Y) and 6 (Z). Status bit 7 is the OR of the three.
- R8: `drdy` is high exactly when `drdy_en` is high and status bit 3 is set.
- R9: A low byte read copies that axis's current high byte into a shadow. The next high byte read of that axis returns the shadow, even if new samples arrived in between, and consumes it. A high byte read with no pending shadow returns the live high byte.
- R10: `rd_data` is valid in the same cycle that `rd_en` is high, and reading the status byte changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| align_left | input | 1 | 0: right-justified with sign extension, 1: left-justified |
| drdy_en | input | 1 | Enables the data-ready output |
| smp_vld | input | 1 | Sample strobe for all three axes |
| smp_x | input | 12 | X axis sample, two's complement |
| smp_y | input | 12 | Y axis sample, two's complement |
| smp_z | input | 12 | Z axis sample, two's complement |
| rd_en | input | 1 | Register read strobe from the bus slave |
| rd_addr | input | 7 | Register read address |
| rd_data | output | 8 | Read data, valid while rd_en is high |
| drdy | output | 1 | Data-ready output |

## Verification
A wrong flag state shows up on the very next status read and on `drdy`, both one clock after the strobe or the high byte read that should have changed it. This covers a new-data flag that fails to clear, an overrun that latches on the clear-and-set collision, or a combined bit built from the wrong axes. A corrupted shadow appears only on the high byte read that follows a low byte read. The bench therefore places a fresh sample between the two accesses, so that a live value and a stale shadow give different bytes. Formatting faults appear on the first byte read in each alignment mode, using samples with the sign bit both set and clear.

// File: rtl/axis_out_pkg.sv
package axis_out_pkg;
    parameter int SAMPLE_W    = 12;
    parameter int BYTE_W      = 8;
    parameter int WORD_W      = 2 * BYTE_W;
    parameter int ADDR_W      = 7;
    parameter int NUM_AXES    = 3;
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h27;
    parameter logic [ADDR_W-1:0] AXIS_BASE   = 7'h28;
endpackage

// File: rtl/axis_fmt.sv
module axis_fmt #(
    parameter int SAMPLE_W = 12,
    parameter int WORD_W   = 16
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                left_i,
    output logic [WORD_W-1:0]   word_o
);
    localparam int PAD_W = WORD_W - SAMPLE_W;

    generate
        if (PAD_W > 0) begin : g_pad
            logic [WORD_W-1:0] right_w;
            logic [WORD_W-1:0] left_w;
            assign right_w = {{PAD_W{sample_i[SAMPLE_W-1]}}, sample_i};
            assign left_w  = {sample_i, {PAD_W{1'b0}}};
            assign word_o  = left_i ? left_w : right_w;
        end else begin : g_full
            logic unused_left;
            assign unused_left = left_i;
            assign word_o      = sample_i[SAMPLE_W-1 -: WORD_W];
        end
    endgenerate
endmodule

// File: rtl/axis_lane.sv
module axis_lane #(
    parameter int SAMPLE_W = 12,
    parameter int BYTE_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                left_i,
    input  logic                rd_lsb_i,
    input  logic                rd_msb_i,
    output logic [BYTE_W-1:0]   lsb_o,
    output logic [BYTE_W-1:0]   msb_o,
    output logic                da_o,
    output logic                ovr_o
);
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        logic [SAMPLE_W-1:0] data;
        logic                da;
        logic                ovr;
        logic [BYTE_W-1:0]   shadow;
        logic                shadow_vld;
    } lane_t;

    lane_t             st_d, st_q;
    logic [WORD_W-1:0] word_w;
    logic [BYTE_W-1:0] live_msb;

    axis_fmt #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_fmt (
        .sample_i (st_q.data),
        .left_i   (left_i),
        .word_o   (word_w)
    );

    assign live_msb = word_w[WORD_W-1:BYTE_W];

    always_comb begin
        logic da_c;
        logic ovr_c;
        st_d  = st_q;
        da_c  = rd_msb_i ? 1'b0 : st_q.da;
        ovr_c = rd_msb_i ? 1'b0 : st_q.ovr;
        st_d.da  = da_c;
        st_d.ovr = ovr_c;
        if (strobe_i) begin
            st_d.data = sample_i;
            st_d.ovr  = ovr_c | da_c;
            st_d.da   = 1'b1;
        end
        if (rd_lsb_i) begin
            st_d.shadow     = live_msb;
            st_d.shadow_vld = 1'b1;
        end else if (rd_msb_i) begin
            st_d.shadow_vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lsb_o = word_w[BYTE_W-1:0];
    assign msb_o = st_q.shadow_vld ? st_q.shadow : live_msb;
    assign da_o  = st_q.da;
    assign ovr_o = st_q.ovr;

    assert_da_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> da_o);
    assert_msb_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_msb_i && !strobe_i) |=> (!da_o && !ovr_o));
    assert_collision_no_ovr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_msb_i && strobe_i) |=> (da_o && !ovr_o));
    assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && da_o && !rd_msb_i) |=> ovr_o);
    assert_ovr_needs_da_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |-> da_o);
endmodule

// File: rtl/axis_data_out.sv
module axis_data_out
    import axis_out_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                align_left,
    input  logic                drdy_en,
    input  logic                smp_vld,
    input  logic [SAMPLE_W-1:0] smp_x,
    input  logic [SAMPLE_W-1:0] smp_y,
    input  logic [SAMPLE_W-1:0] smp_z,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [BYTE_W-1:0]   rd_data,
    output logic                drdy
);
    localparam int ALL_BIT = NUM_AXES;
    localparam int OVR_LSB = NUM_AXES + 1;
    localparam int ANY_BIT = 2 * NUM_AXES + 1;

    logic [SAMPLE_W-1:0] smp_arr [NUM_AXES];
    logic [NUM_AXES-1:0] rd_lsb, rd_msb, da_v, ovr_v;
    logic [BYTE_W-1:0]   lsb_v [NUM_AXES];
    logic [BYTE_W-1:0]   msb_v [NUM_AXES];
    logic [BYTE_W-1:0]   status_d;
    logic [BYTE_W-1:0]   rd_data_d;

    assign smp_arr[0] = smp_x;
    assign smp_arr[1] = smp_y;
    assign smp_arr[2] = smp_z;

    generate
        for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
            localparam logic [ADDR_W-1:0] LSB_ADDR = AXIS_BASE + ADDR_W'(2 * a);
            localparam logic [ADDR_W-1:0] MSB_ADDR = AXIS_BASE + ADDR_W'(2 * a + 1);

            assign rd_lsb[a] = rd_en && (rd_addr == LSB_ADDR);
            assign rd_msb[a] = rd_en && (rd_addr == MSB_ADDR);

            axis_lane #(.SAMPLE_W(SAMPLE_W), .BYTE_W(BYTE_W)) u_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .strobe_i (smp_vld),
                .sample_i (smp_arr[a]),
                .left_i   (align_left),
                .rd_lsb_i (rd_lsb[a]),
                .rd_msb_i (rd_msb[a]),
                .lsb_o    (lsb_v[a]),
                .msb_o    (msb_v[a]),
                .da_o     (da_v[a]),
                .ovr_o    (ovr_v[a])
            );
        end
    endgenerate

    always_comb begin
        status_d                               = '0;
        status_d[NUM_AXES-1:0]                 = da_v;
        status_d[ALL_BIT]                      = &da_v;
        status_d[OVR_LSB +: NUM_AXES]          = ovr_v;
        status_d[ANY_BIT]                      = |ovr_v;
    end

    always_comb begin
        rd_data_d = '0;
        if (rd_en && rd_addr == STATUS_ADDR) rd_data_d = status_d;
        for (int a = 0; a < NUM_AXES; a++) begin
            if (rd_lsb[a]) rd_data_d = lsb_v[a];
            if (rd_msb[a]) rd_data_d = msb_v[a];
        end
    end

    assign rd_data = rd_data_d;
    assign drdy    = drdy_en && status_d[ALL_BIT];

    assert_drdy_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && drdy_en) ##1 drdy_en |-> drdy);
    assert_drdy_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drdy |-> drdy_en);
endmodule

// File: tb/axis_data_out_tb.sv
module axis_data_out_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        align_left = 1'b0;
    logic        drdy_en = 1'b1;
    logic        smp_vld = 1'b0;
    logic [11:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic        rd_en = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        drdy;

    int n_total = 0;
    int n_fail  = 0;

    typedef struct { logic [7:0] exp; string req; } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    axis_data_out u_dut (
        .clk(clk), .rst_n(rst_n), .align_left(align_left), .drdy_en(drdy_en),
        .smp_vld(smp_vld), .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .drdy(drdy)
    );

    // monitor: compare every read against the scoreboard
    always @(negedge clk) begin
        if (rd_en && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_total++;
            if (rd_data !== it.exp) begin
                n_fail++;
                $display("FAIL %s addr %0h: got %0h expected %0h", it.req, rd_addr, rd_data, it.exp);
            end
        end
    end

    task automatic step(input logic vld, input logic [11:0] x, input logic [11:0] y,
                        input logic [11:0] z, input logic rd, input logic [6:0] addr,
                        input logic [7:0] exp, input string req);
        @(posedge clk);
        #1;
        smp_vld = vld; smp_x = x; smp_y = y; smp_z = z;
        rd_en = rd; rd_addr = addr;
        if (rd) sb_q.push_back('{exp, req});
    endtask

    task automatic rd(input logic [6:0] addr, input logic [7:0] exp, input string req);
        step(1'b0, 12'h0, 12'h0, 12'h0, 1'b1, addr, exp, req);
    endtask

    task automatic smp(input logic [11:0] x, input logic [11:0] y, input logic [11:0] z);
        step(1'b1, x, y, z, 1'b0, 7'h0, 8'h0, "");
    endtask

    task automatic chk_drdy(input logic exp, input string req);
        @(negedge clk);
        n_total++;
        if (drdy !== exp) begin
            n_fail++;
            $display("FAIL %s drdy: got %0b expected %0b", req, drdy, exp);
        end
    endtask

    initial begin
        #1_000_000;
        n_total++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(7'h27, 8'h00, "R1");
        chk_drdy(1'b0, "R1");
        rd(7'h29, 8'h00, "R1");
        // R5 strobe sets flags, R8 drdy
        smp(12'h8A5, 12'h123, 12'hFFF);
        rd(7'h27, 8'h0F, "R5");
        chk_drdy(1'b1, "R8");
        // R3 right-justified, sign copy
        rd(7'h28, 8'hA5, "R3");
        rd(7'h29, 8'hF8, "R3");
        rd(7'h27, 8'h06, "R6");
        chk_drdy(1'b0, "R8");
        rd(7'h2A, 8'h23, "R3");
        rd(7'h2B, 8'h01, "R3");
        rd(7'h27, 8'h04, "R6");
        // R7 overrun on Z
        smp(12'h7FF, 12'h800, 12'h001);
        rd(7'h27, 8'hCF, "R7");
        // R9 live high byte without prior low read; R6 clears Z
        rd(7'h2D, 8'h00, "R9");
        rd(7'h27, 8'h03, "R6");
        // R4 left-justified
        align_left = 1'b1;
        rd(7'h28, 8'hF0, "R4");
        rd(7'h29, 8'h7F, "R4");
        rd(7'h2A, 8'h00, "R4");
        rd(7'h2B, 8'h80, "R4");
        // R9 shadow survives a new sample
        rd(7'h2C, 8'h10, "R9");
        smp(12'h100, 12'h200, 12'hABC);
        rd(7'h2D, 8'h00, "R9");
        rd(7'h2D, 8'hAB, "R9");
        rd(7'h27, 8'h03, "R6");
        // R6 collision: X high read with strobe, Y overruns
        step(1'b1, 12'h555, 12'h666, 12'h777, 1'b1, 7'h29, 8'h10, "R6");
        rd(7'h27, 8'hAF, "R6");
        // R10 status read has no side effect; R2 unmapped
        rd(7'h27, 8'hAF, "R10");
        rd(7'h30, 8'h00, "R2");
        rd(7'h26, 8'h00, "R2");
        // R8 enable gating
        drdy_en = 1'b0;
        chk_drdy(1'b0, "R8");
        drdy_en = 1'b1;
        chk_drdy(1'b1, "R8");
        step(1'b0, 12'h0, 12'h0, 12'h0, 1'b0, 7'h0, 8'h0, "");
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule